// File: doc/BRIEF.md
# Pipelined Page-Program Front End for NAND Flash

This block is the device-side command front end for back-to-back page programming. The host opens a page with a load command, supplies two column bytes and three row bytes, and then streams data bytes into a page-sized staging buffer (the cache). A commit command copies the staging buffer into a second page buffer (the data register) and starts a modelled array program of that page. Once the copy is done, the block is ready for the next page. It can therefore stage page N+1 while page N is still being programmed.

The array program is modelled by a cycle timer. Its outcome is taken from an injected fail input. The block tracks a pass/fail flag for the page being programmed and one for the page before it. Pages that are chained into a running program must stay inside one erase block. A host-visible status byte reports whether the cache is ready, whether the array is idle, and both error flags.

Top module: `nand_cache_prog`

## Requirements
- R1: A program sequence is command 80h, then exactly five `addr_we` bytes (column low, column high, row bits 7:0, row bits 15:8, row bits 23:16), then `data_we` bytes. Each data byte is stored in the cache at the current column, and the column then advances by one.
- R2: Data bytes whose column is at or beyond PAGE_BYTES are dropped and do not wrap. Every cache byte not written since the last 80h reaches the data register as FFh.
- R3: Command 15h issued while no array program runs drives `rb_o` low for exactly XFER_CYC cycles. `arr_busy_o` then rises for PROG_CYC cycles, and `arr_row_o` holds the committed row for that whole time.
- R4: Command 15h issued while an array program runs keeps `rb_o` low until that program ends, and only then performs the XFER_CYC-cycle copy. The low time is therefore longer than XFER_CYC.
- R5: The erase block of a row is row / PAGES_PER_BLK. A page committed while an earlier program is still running, whose block differs from the block of the page that opened the chain, finishes with its error flag set, whatever the value of `fail_inj`.
- R6: Status bit 6 equals `rb_o` (the cache can take a new page). Status bit 5 is 1 only when no array program runs and no copy is in progress. Bits 7, 4, 3 and 2 read 0.
- R7: Bit 0 holds the result of the page in the data register: it is cleared when that page's program starts and set at its last program cycle if `fail_inj` is high. When the next program starts, bit 0 moves into bit 1 (the previous page). Both bits are 0 after reset.
- R8: Commands 70h and 78h both return the status byte. It appears on `sts_o` with `sts_vld_o` high in the cycle after the command.
- R9: Out-of-sequence input is ignored: address bytes outside the address phase, data bytes outside the data phase, 15h outside the data phase, and 80h during a copy or a held-off commit.
- R10: `arr_rdata_o` returns the data-register byte at `arr_raddr` one cycle after the address is presented. The contents change only during a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | `bus_i` carries a command byte |
| addr_we | input | 1 | `bus_i` carries an address byte |
| data_we | input | 1 | `bus_i` carries a data byte |
| bus_i | input | 8 | Host byte |
| fail_inj | input | 1 | Modelled program failure, sampled at the last program cycle |
| arr_raddr | input | COL_W | Data-register read address |
| rb_o | output | 1 | Ready (1) / busy (0) for a new page |
| sts_o | output | 8 | Status byte |
| sts_vld_o | output | 1 | `sts_o` answers a status command |
| arr_busy_o | output | 1 | Array program running |
| arr_row_o | output | 24 | Row being programmed |
| arr_rdata_o | output | 8 | Data-register byte read |

## Verification
The checker assumes that at most one of `cmd_we`, `addr_we` and `data_we` is high in any cycle. The bench drives each byte alone, one byte per cycle, on the falling edge. The ready, status and program-row assertions also rely on the host never asserting the commit command again while a copy is in progress. The bench keeps to this by waiting for `rb_o` before opening each new page.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;
  typedef enum logic [2:0] {
    CP_IDLE, CP_ADDR, CP_DATA, CP_HOLD, CP_COPY
  } cp_state_t;

  localparam logic [7:0] OP_LOAD   = 8'h80;
  localparam logic [7:0] OP_COMMIT = 8'h15;
  localparam logic [7:0] OP_STAT_A = 8'h70;
  localparam logic [7:0] OP_STAT_B = 8'h78;
  localparam int         ADDR_BYTES = 5;
endpackage

// File: rtl/ncp_page_ram.sv
module ncp_page_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ncp_timer.sv
module ncp_timer #(
  parameter int CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int W = $clog2(CYC + 1);
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign done = busy && (cnt == LAST);
endmodule

// File: rtl/nand_cache_prog.sv
module nand_cache_prog
  import nand_cp_pkg::*;
#(
  parameter int PAGE_BYTES    = 64,
  parameter int PAGES_PER_BLK = 64,
  parameter int XFER_CYC      = 72,
  parameter int PROG_CYC      = 400,
  parameter int COL_W         = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic             addr_we,
  input  logic             data_we,
  input  logic [7:0]       bus_i,
  input  logic             fail_inj,
  input  logic [COL_W-1:0] arr_raddr,
  output logic             rb_o,
  output logic [7:0]       sts_o,
  output logic             sts_vld_o,
  output logic             arr_busy_o,
  output logic [23:0]      arr_row_o,
  output logic [7:0]       arr_rdata_o
);
  localparam int ROW_W   = 24;
  localparam int BLK_LSB = $clog2(PAGES_PER_BLK);
  localparam int XW      = $clog2(XFER_CYC + 1);
  localparam logic [XW-1:0] X_LAST = XW'(XFER_CYC - 1);
  localparam logic [XW-1:0] X_PB   = XW'(PAGE_BYTES);
  localparam logic [15:0]   C_PB   = 16'(PAGE_BYTES);

  cp_state_t               st;
  logic [2:0]              acnt;
  logic [15:0]             col;
  logic [ROW_W-1:0]        row_ld;
  logic [ROW_W-BLK_LSB-1:0] blk_base;
  logic                    cross_ld, cross_arr;
  logic [PAGE_BYTES-1:0]   filled;
  logic [XW-1:0]           xcnt;
  logic                    err_cur, err_prev;
  logic                    cp_v, cp_msk;
  logic [COL_W-1:0]        cp_idx;
  logic [7:0]              cache_q;

  logic prog_busy, prog_done, launch, wr_ok, rd_en, cache_rdy, arr_rdy;
  logic [7:0] status_now;

  assign cache_rdy  = !(st == CP_HOLD || st == CP_COPY);
  assign arr_rdy    = !prog_busy && (st != CP_COPY);
  assign status_now = {1'b0, cache_rdy, arr_rdy, 3'b000, err_prev, err_cur};
  assign launch     = (st == CP_COPY) && (xcnt == X_LAST);
  assign wr_ok      = data_we && !cmd_we && !addr_we && (st == CP_DATA) && (col < C_PB);
  assign rd_en      = (st == CP_COPY) && (xcnt < X_PB);

  // Host sequencing, copy pacing and status flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CP_IDLE;
      acnt      <= '0;
      col       <= '0;
      row_ld    <= '0;
      blk_base  <= '0;
      cross_ld  <= 1'b0;
      cross_arr <= 1'b0;
      filled    <= '0;
      xcnt      <= '0;
      err_cur   <= 1'b0;
      err_prev  <= 1'b0;
      sts_o     <= '0;
      sts_vld_o <= 1'b0;
      arr_row_o <= '0;
    end else begin
      sts_vld_o <= 1'b0;
      if (cmd_we) begin
        if (bus_i == OP_STAT_A || bus_i == OP_STAT_B) begin
          sts_vld_o <= 1'b1;
          sts_o     <= status_now;
        end else if (bus_i == OP_LOAD && cache_rdy) begin
          st     <= CP_ADDR;
          acnt   <= '0;
          col    <= '0;
          row_ld <= '0;
          filled <= '0;
        end else if (bus_i == OP_COMMIT && st == CP_DATA) begin
          cross_ld <= prog_busy && (row_ld[ROW_W-1:BLK_LSB] != blk_base);
          if (!prog_busy) blk_base <= row_ld[ROW_W-1:BLK_LSB];
          st   <= prog_busy ? CP_HOLD : CP_COPY;
          xcnt <= '0;
        end
      end else if (addr_we && st == CP_ADDR) begin
        case (acnt)
          3'd0:    col[7:0]      <= bus_i;
          3'd1:    col[15:8]     <= bus_i;
          3'd2:    row_ld[7:0]   <= bus_i;
          3'd3:    row_ld[15:8]  <= bus_i;
          default: row_ld[23:16] <= bus_i;
        endcase
        acnt <= acnt + 1'b1;
        if (acnt == 3'(ADDR_BYTES - 1)) st <= CP_DATA;
      end else if (wr_ok) begin
        filled[col[COL_W-1:0]] <= 1'b1;
        col <= col + 1'b1;
      end

      if (st == CP_HOLD && !prog_busy) begin
        st   <= CP_COPY;
        xcnt <= '0;
      end else if (st == CP_COPY) begin
        if (launch) st <= CP_IDLE;
        else        xcnt <= xcnt + 1'b1;
      end

      if (launch) begin
        err_prev  <= err_cur;
        err_cur   <= 1'b0;
        arr_row_o <= row_ld;
        cross_arr <= cross_ld;
      end else if (prog_done) begin
        err_cur <= fail_inj || cross_arr;
      end
    end
  end

  // Cache-to-data copy, one byte per cycle with a one-cycle read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      cp_v   <= 1'b0;
      cp_msk <= 1'b0;
      cp_idx <= '0;
    end else begin
      cp_v   <= rd_en;
      cp_msk <= filled[xcnt[COL_W-1:0]];
      cp_idx <= xcnt[COL_W-1:0];
    end
  end

  ncp_page_ram #(.DEPTH(PAGE_BYTES), .AW(COL_W)) u_cache (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (col[COL_W-1:0]),
    .wdata (bus_i),
    .raddr (xcnt[COL_W-1:0]),
    .rdata (cache_q)
  );

  ncp_page_ram #(.DEPTH(PAGE_BYTES), .AW(COL_W)) u_dreg (
    .clk   (clk),
    .we    (cp_v),
    .waddr (cp_idx),
    .wdata (cp_msk ? cache_q : 8'hFF),
    .raddr (arr_raddr),
    .rdata (arr_rdata_o)
  );

  ncp_timer #(.CYC(PROG_CYC)) u_prog (
    .clk   (clk),
    .rst   (rst),
    .start (launch),
    .busy  (prog_busy),
    .done  (prog_done)
  );

  assign rb_o       = cache_rdy;
  assign arr_busy_o = prog_busy;
endmodule

// File: rtl/ncp_checker.sv
module ncp_checker (
  input logic        clk,
  input logic        rst,
  input logic        cmd_we,
  input logic        addr_we,
  input logic        data_we,
  input logic [7:0]  bus_i,
  input logic        rb_o,
  input logic [7:0]  sts_o,
  input logic        sts_vld_o,
  input logic        arr_busy_o,
  input logic [23:0] arr_row_o
);
  a_in_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_we, addr_we, data_we}));

  // R3: an array program only begins after a copy held the cache busy
  a_r3_copy_first: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_busy_o) |-> $past(!rb_o));

  // R3: programmed row does not move while the array is busy
  a_r3_row_hold: assert property (@(posedge clk) disable iff (rst)
    arr_busy_o && $past(arr_busy_o) |-> $stable(arr_row_o));

  // R8: status only answers a status command
  a_r8_vld_src: assert property (@(posedge clk) disable iff (rst)
    sts_vld_o |-> $past(cmd_we && (bus_i == 8'h70 || bus_i == 8'h78)));

  // R6: bit 6 mirrors ready
  a_r6_bit6: assert property (@(posedge clk) disable iff (rst)
    sts_vld_o |-> (sts_o[6] == $past(rb_o)));

  // R6: bit 5 low while programming
  a_r6_bit5: assert property (@(posedge clk) disable iff (rst)
    sts_vld_o && $past(arr_busy_o) |-> !sts_o[5]);

  // R6: reserved bits
  a_r6_zero: assert property (@(posedge clk) disable iff (rst)
    sts_vld_o |-> (sts_o[7] == 1'b0 && sts_o[4:2] == 3'b000));
endmodule

bind nand_cache_prog ncp_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_we     (cmd_we),
  .addr_we    (addr_we),
  .data_we    (data_we),
  .bus_i      (bus_i),
  .rb_o       (rb_o),
  .sts_o      (sts_o),
  .sts_vld_o  (sts_vld_o),
  .arr_busy_o (arr_busy_o),
  .arr_row_o  (arr_row_o)
);

// File: tb/tb_nand_cache_prog.sv
module tb_nand_cache_prog;
  localparam int CLK_PERIOD = 10;
  localparam int PB   = 16;
  localparam int PPB  = 4;
  localparam int XC   = 20;
  localparam int PC   = 60;
  localparam int CW   = $clog2(PB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 0, addr_we = 0, data_we = 0, fail_inj = 0;
  logic [7:0] bus_i = '0;
  logic [CW-1:0] arr_raddr = '0;
  logic rb_o, sts_vld_o, arr_busy_o;
  logic [7:0] sts_o, arr_rdata_o;
  logic [23:0] arr_row_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cache_prog #(.PAGE_BYTES(PB), .PAGES_PER_BLK(PPB), .XFER_CYC(XC), .PROG_CYC(PC)) dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .addr_we(addr_we), .data_we(data_we),
    .bus_i(bus_i), .fail_inj(fail_inj), .arr_raddr(arr_raddr), .rb_o(rb_o),
    .sts_o(sts_o), .sts_vld_o(sts_vld_o), .arr_busy_o(arr_busy_o),
    .arr_row_o(arr_row_o), .arr_rdata_o(arr_rdata_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_we = 1; bus_i = c; @(negedge clk); cmd_we = 0;
  endtask

  task automatic adr(input logic [7:0] b);
    addr_we = 1; bus_i = b; @(negedge clk); addr_we = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    data_we = 1; bus_i = b; @(negedge clk); data_we = 0;
  endtask

  task automatic open_page(input logic [15:0] c, input logic [23:0] r);
    cmd(8'h80);
    adr(c[7:0]); adr(c[15:8]); adr(r[7:0]); adr(r[15:8]); adr(r[23:16]);
  endtask

  task automatic read_sts(input logic [7:0] op, output logic [7:0] s);
    cmd(op);
    check(sts_vld_o === 1'b1, "R8 status valid", sts_vld_o, 1);
    s = sts_o;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rb_o) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (arr_busy_o || !rb_o) @(negedge clk);
  endtask

  task automatic rd_dreg(input int a, output logic [7:0] b);
    arr_raddr = CW'(a); @(negedge clk); b = arr_rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check(rb_o === 1'b1, "R6 ready after reset", rb_o, 1);
    read_sts(8'h70, s);
    check(s == 8'h60, "R7 status after reset", s, 8'h60);
  endtask

  task automatic t_partial();
    logic [7:0] s, b; int n;
    open_page(16'd2, 24'd5);
    wr(8'hAA); wr(8'hBB); wr(8'hCC);
    cmd(8'h15);
    wait_rdy(n);
    check(n == XC, "R3 copy busy length", n, XC);
    check(arr_busy_o === 1'b1 && arr_row_o == 24'd5, "R3 program row", arr_row_o, 5);
    read_sts(8'h70, s);
    check(s == 8'h40, "R6 status while programming", s, 8'h40);
    rd_dreg(0, b); check(b == 8'hFF, "R2 unwritten byte", b, 8'hFF);
    rd_dreg(2, b); check(b == 8'hAA, "R1 first byte at column", b, 8'hAA);
    rd_dreg(4, b); check(b == 8'hCC, "R1 column advance", b, 8'hCC);
    rd_dreg(5, b); check(b == 8'hFF, "R2 byte after data", b, 8'hFF);
    wait_idle();
    read_sts(8'h70, s);
    check(s == 8'h60, "R7 passed page", s, 8'h60);
  endtask

  task automatic t_overflow();
    logic [7:0] b; int n;
    open_page(16'(PB - 2), 24'd6);
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    cmd(8'h15);
    wait_rdy(n);
    rd_dreg(PB - 2, b); check(b == 8'h11, "R2 byte before end", b, 8'h11);
    rd_dreg(PB - 1, b); check(b == 8'h22, "R2 last byte", b, 8'h22);
    rd_dreg(0, b);      check(b == 8'hFF, "R2 no wrap", b, 8'hFF);
    wait_idle();
  endtask

  task automatic t_pipe();
    logic [7:0] s, b; int n;
    fail_inj = 1;
    open_page(16'd0, 24'd8); wr(8'h01); cmd(8'h15);
    wait_rdy(n);
    open_page(16'd0, 24'd9); wr(8'h5A); cmd(8'h15);
    wait_rdy(n);
    fail_inj = 0;
    check(n > XC, "R4 commit held off", n, XC + 1);
    check(arr_row_o == 24'd9, "R4 chained row", arr_row_o, 9);
    read_sts(8'h70, s);
    check(s == 8'h42, "R7 failed page moved to bit1", s, 8'h42);
    rd_dreg(0, b); check(b == 8'h5A, "R10 data register after chain", b, 8'h5A);
    wait_idle();
    read_sts(8'h78, s);
    check(s == 8'h62, "R8 alt status, R7 bits", s, 8'h62);
  endtask

  task automatic t_cross();
    logic [7:0] s; int n;
    open_page(16'd0, 24'd12); wr(8'h03); cmd(8'h15);
    wait_rdy(n);
    open_page(16'd0, 24'd16); wr(8'h04); cmd(8'h15);
    wait_rdy(n);
    wait_idle();
    read_sts(8'h70, s);
    check(s == 8'h61, "R5 block crossing fails", s, 8'h61);
  endtask

  task automatic t_ignore();
    logic [7:0] b, s; int n;
    cmd(8'h15);
    check(rb_o === 1'b1 && arr_busy_o === 1'b0, "R9 stray commit", arr_busy_o, 0);
    wr(8'hEE);
    open_page(16'd0, 24'd20);
    adr(8'h09);
    wr(8'h77);
    cmd(8'h15);
    wait_rdy(n);
    rd_dreg(0, b); check(b == 8'h77, "R9 extra address byte", b, 8'h77);
    rd_dreg(1, b); check(b == 8'hFF, "R9 stray data byte", b, 8'hFF);
    read_sts(8'h70, s);
    rd_dreg(0, b); check(b == 8'h77, "R10 contents hold", b, 8'h77);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_partial();
    t_overflow();
    t_pipe();
    t_cross();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule